// File: doc/BRIEF.md
# Multiplexed LCD Drive Waveform Sequencer

This block produces, on every clock, a two-bit level-select code for each of four LCD backplane pins and for every segment pin. An external analog stage turns each code into one of four voltages between ground and the LCD supply. The sequencer divides each display frame into time slots, one per backplane in use. In each slot it drives the active backplane to full swing and parks the other backplanes at a bias point. Each segment is driven so that its element sees either the on voltage or the off voltage, depending on a stored display bit. After every frame all codes are mirrored, so the element voltages average to zero.

The pixel data lives in an internal display store of one 4-bit word per segment, with one bit per backplane. Words arrive on a valid/ready write stream. The store never applies back-pressure: `wr_ready` is held high, and the stream is accepted on every cycle in which `wr_valid` is high. The multiplex ratio, the bias choice and the frame-rate code are plain control inputs. The sequencer takes them in only at frame boundaries, or at any time while the display is disabled, so a frame is never drawn with mixed settings. Dropping the enable blanks every pin to ground and restarts the sequence.

Top module: `lcd_wave_seq`

## Requirements
- R1: While reset is asserted and after its release, every backplane and segment code is 2'b00 and `wr_ready` is 1.
- R2: A clock edge that samples `disp_en` low sets every output code to 2'b00 at that edge. The sequence restarts at slot 0 with positive polarity, and the control inputs are sampled; the first enabled edge then shows slot 0.
- R3: Level codes are 2'b00 ground, 2'b01 one-third, 2'b10 two-thirds (also the half point), 2'b11 supply. In a negative frame every code is the bitwise inverse of its positive-frame code.
- R4: `mux_sel` selects N = `mux_sel`+1 backplanes (0 static, 1 two-way, 2 three-way, 3 four-way). In slot k backplane k is active: 2'b00 in a positive frame. The other used backplanes are 2'b10. A backplane with index of N or more carries backplane 0's code. `bp_lvl[2b+1:2b]` is backplane b.
- R5: In static mode backplane 0 is always 2'b00 in a positive frame. A segment is 2'b11 when its bit 0 is set and 2'b00 otherwise.
- R6: With `bias_half`=1 in a multiplex mode, a segment whose bit is set is 2'b11 and one whose bit is clear is 2'b00 (positive frame), so segments never use 2'b01 or 2'b10.
- R7: With `bias_half`=0 in a multiplex mode, a segment whose bit is set is 2'b11 and one whose bit is clear is 2'b01 (positive frame).
- R8: In slot k, segment s uses bit k of display word s. `seg_lvl[2s+1:2s]` is segment s.
- R9: One phase lasts P = floor(CLK_HZ / (12*(60+5*c))) cycles, where c is `frame_rate` clamped to 6. A frame lasts 12*P enabled cycles, split into N equal slots.
- R10: `mux_sel`, `bias_half` and `frame_rate` take effect only at the edge that ends a frame, or while disabled. Changes in mid-frame do not alter the running frame.
- R11: A write with `wr_valid` high and `wr_addr` below NUM_SEG stores `wr_data` at that edge and shows on the outputs from the next edge. Addresses of NUM_SEG or more are ignored.
- R12: The polarity starts positive after enable and alternates at every frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_en | input | 1 | Display enable; low blanks all pins |
| mux_sel | input | 2 | Multiplex ratio code |
| bias_half | input | 1 | 1 selects half bias, 0 third bias |
| frame_rate | input | 3 | Frame frequency code, 60 Hz + 5 Hz steps |
| wr_valid | input | 1 | Display word write valid |
| wr_ready | output | 1 | Write ready, always 1 |
| wr_addr | input | $clog2(NUM_SEG+1) | Segment index of the write |
| wr_data | input | 4 | Display word, bit k for backplane k |
| bp_lvl | output | 8 | Backplane level codes, 2 bits per backplane |
| seg_lvl | output | 2*NUM_SEG | Segment level codes, 2 bits per segment |

## Verification
On every cycle the assertions check four things. Disabling blanks the pins and rewinds the slot and polarity. The slot never exceeds the multiplex ratio. The settings stay frozen inside a frame, and exactly one used backplane is at full swing. With half bias or static drive no segment sits at an intermediate level, and each accepted write lands in the store. Some behaviours only the bench's scenarios can show: the exact cycle on which slots and frames turn over for each rate code, the correct bit-to-slot mapping, and the correct mirrored values in negative frames. They also show that a mid-frame change of mode or rate takes hold exactly at the next boundary. The bench shows these by comparing every pin against a behavioural model on every clock.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;
  localparam int BP_COUNT = 4;
  localparam int PHASES_PER_FRAME = 12;

  typedef enum logic [1:0] {
    MUX_STATIC = 2'd0,
    MUX_TWO    = 2'd1,
    MUX_THREE  = 2'd2,
    MUX_FOUR   = 2'd3
  } mux_e;

  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_GND   = 2'b00;
  localparam lvl_t LVL_THIRD = 2'b01;
  localparam lvl_t LVL_TWO3  = 2'b10;
  localparam lvl_t LVL_SUP   = 2'b11;

  // Cycles per phase for a frame-rate code (60 Hz + 5 Hz per step, capped at 90 Hz)
  function automatic int phase_len(int clk_hz, int code);
    int c;
    c = (code > 6) ? 6 : code;
    return clk_hz / (PHASES_PER_FRAME * (60 + 5 * c));
  endfunction

  // Phases per slot: 12 divided by the number of backplanes in use
  function automatic logic [3:0] phases_per_slot(mux_e m);
    case (m)
      MUX_STATIC: return 4'd12;
      MUX_TWO:    return 4'd6;
      MUX_THREE:  return 4'd4;
      default:    return 4'd3;
    endcase
  endfunction
endpackage

// File: rtl/lcdseq_timebase.sv
module lcdseq_timebase
  import lcdseq_pkg::*;
#(
  parameter int CLK_HZ = 21600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  mux_e       mux_i,
  input  logic       half_i,
  input  logic [2:0] rate_i,
  output logic [1:0] slot_o,
  output logic       pol_o,
  output mux_e       mux_o,
  output logic       half_o
);
  localparam int PMAX = phase_len(CLK_HZ, 0);
  localparam int DW   = (PMAX < 2) ? 1 : $clog2(PMAX);
  localparam logic [DW-1:0] RELOAD0 = DW'(PMAX - 1);

  logic [DW-1:0] reload_tab [8];
  for (genvar g = 0; g < 8; g++) begin : g_tab
    assign reload_tab[g] = DW'(phase_len(CLK_HZ, g) - 1);
  end

  logic [DW-1:0] div_q;
  logic [3:0]    ph_q;
  logic [1:0]    slot_q;
  logic          pol_q;
  mux_e          mux_q;
  logic          half_q;
  logic [2:0]    rate_q;

  logic tick, ph_last, slot_last, frame_end;
  always_comb begin
    tick      = (div_q == '0);
    ph_last   = (ph_q == phases_per_slot(mux_q) - 4'd1);
    slot_last = (slot_q == mux_q);
    frame_end = tick && ph_last && slot_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= RELOAD0;
      ph_q   <= '0;
      slot_q <= '0;
      pol_q  <= 1'b0;
      mux_q  <= MUX_STATIC;
      half_q <= 1'b0;
      rate_q <= '0;
    end else if (!en_i) begin
      div_q  <= reload_tab[rate_i];
      ph_q   <= '0;
      slot_q <= '0;
      pol_q  <= 1'b0;
      mux_q  <= mux_i;
      half_q <= half_i;
      rate_q <= rate_i;
    end else if (frame_end) begin
      div_q  <= reload_tab[rate_i];
      ph_q   <= '0;
      slot_q <= '0;
      pol_q  <= ~pol_q;
      mux_q  <= mux_i;
      half_q <= half_i;
      rate_q <= rate_i;
    end else if (tick) begin
      div_q <= reload_tab[rate_q];
      if (ph_last) begin
        ph_q   <= '0;
        slot_q <= slot_q + 2'd1;
      end else begin
        ph_q <= ph_q + 4'd1;
      end
    end else begin
      div_q <= div_q - DW'(1);
    end
  end

  assign slot_o = slot_q;
  assign pol_o  = pol_q;
  assign mux_o  = mux_q;
  assign half_o = half_q;

  AST_SLOT_WITHIN_MUX: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= mux_q); // R4
  AST_CFG_FROZEN_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !frame_end) |=> ($stable(mux_q) && $stable(half_q) && $stable(rate_q))); // R10
  AST_REWIND_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (slot_q == 2'd0 && !pol_q)); // R2
  AST_POL_TURNS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && frame_end) |=> (pol_q != $past(pol_q))); // R12
endmodule

// File: rtl/lcdseq_dispram.sv
module lcdseq_dispram #(
  parameter int NUM_SEG = 160,
  parameter int AW      = $clog2(NUM_SEG + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid_i,
  input  logic [AW-1:0]          wr_addr_i,
  input  logic [3:0]             wr_data_i,
  output logic [NUM_SEG*4-1:0]   bits_o
);
  logic [3:0] mem [NUM_SEG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SEG; s++) mem[s] <= '0;
    end else if (wr_valid_i) begin
      for (int s = 0; s < NUM_SEG; s++)
        if (wr_addr_i == AW'(s)) mem[s] <= wr_data_i;
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_out
    assign bits_o[s*4 +: 4] = mem[s];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && (int'(wr_addr_i) < NUM_SEG)) |=>
      (bits_o[int'($past(wr_addr_i))*4 +: 4] == $past(wr_data_i))); // R11
endmodule

// File: rtl/lcdseq_levels.sv
module lcdseq_levels
  import lcdseq_pkg::*;
#(
  parameter int NUM_SEG = 160
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_i,
  input  logic [1:0]             slot_i,
  input  logic                   pol_i,
  input  mux_e                   mux_i,
  input  logic                   half_i,
  input  logic [NUM_SEG*4-1:0]   bits_i,
  output logic [BP_COUNT*2-1:0]  bp_lvl_o,
  output logic [NUM_SEG*2-1:0]   seg_lvl_o
);
  logic [BP_COUNT*2-1:0] bp_d;
  logic [NUM_SEG*2-1:0]  seg_d;
  lvl_t                  flip;
  lvl_t                  seg_off;

  assign flip    = {pol_i, pol_i};
  assign seg_off = (mux_i == MUX_STATIC || half_i) ? LVL_GND : LVL_THIRD;

  for (genvar b = 0; b < BP_COUNT; b++) begin : g_bp
    localparam logic [1:0] BI = 2'(b);
    logic active;
    // unused backplanes follow backplane 0
    assign active = (BI <= mux_i) ? (slot_i == BI) : (slot_i == 2'd0);
    assign bp_d[b*2 +: 2] = (active ? LVL_GND : LVL_TWO3) ^ flip;
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [3:0] word;
    assign word = bits_i[s*4 +: 4];
    assign seg_d[s*2 +: 2] = (word[slot_i] ? LVL_SUP : seg_off) ^ flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_lvl_o  <= '0;
      seg_lvl_o <= '0;
    end else if (!en_i) begin
      bp_lvl_o  <= '0;
      seg_lvl_o <= '0;
    end else begin
      bp_lvl_o  <= bp_d;
      seg_lvl_o <= seg_d;
    end
  end

  // Context of the registered codes, kept for the checks below
  logic en_r, pol_r, half_r;
  mux_e mux_r;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r <= 1'b0; pol_r <= 1'b0; half_r <= 1'b0; mux_r <= MUX_STATIC;
    end else begin
      en_r <= en_i; pol_r <= pol_i; half_r <= half_i; mux_r <= mux_i;
    end
  end

  logic [BP_COUNT-1:0] full_swing;
  logic                mid_seen;
  always_comb begin
    for (int b = 0; b < BP_COUNT; b++)
      full_swing[b] = (2'(b) <= mux_r) && (bp_lvl_o[b*2 +: 2] == {pol_r, pol_r});
    mid_seen = 1'b0;
    for (int s = 0; s < NUM_SEG; s++)
      mid_seen = mid_seen | (seg_lvl_o[s*2] ^ seg_lvl_o[s*2+1]);
  end

  AST_BLANK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (bp_lvl_o == '0 && seg_lvl_o == '0)); // R2
  AST_ONE_ACTIVE_BP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_r && mux_r != MUX_STATIC) |-> ($countones(full_swing) == 1)); // R4
  AST_TWO_LEVEL_SEGS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_r && (half_r || mux_r == MUX_STATIC)) |-> !mid_seen); // R6
endmodule

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq
  import lcdseq_pkg::*;
#(
  parameter int NUM_SEG = 160,
  parameter int CLK_HZ  = 21600,
  localparam int AW     = $clog2(NUM_SEG + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  disp_en,
  input  logic [1:0]            mux_sel,
  input  logic                  bias_half,
  input  logic [2:0]            frame_rate,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [AW-1:0]         wr_addr,
  input  logic [3:0]            wr_data,
  output logic [BP_COUNT*2-1:0] bp_lvl,
  output logic [NUM_SEG*2-1:0]  seg_lvl
);
  logic [1:0]           slot;
  logic                 pol;
  mux_e                 mux_cur;
  logic                 half_cur;
  logic [NUM_SEG*4-1:0] bits;

  assign wr_ready = 1'b1;

  lcdseq_timebase #(.CLK_HZ(CLK_HZ)) u_tb (
    .clk(clk), .rst_n(rst_n), .en_i(disp_en), .mux_i(mux_e'(mux_sel)),
    .half_i(bias_half), .rate_i(frame_rate), .slot_o(slot), .pol_o(pol),
    .mux_o(mux_cur), .half_o(half_cur)
  );

  lcdseq_dispram #(.NUM_SEG(NUM_SEG), .AW(AW)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .bits_o(bits)
  );

  lcdseq_levels #(.NUM_SEG(NUM_SEG)) u_lvl (
    .clk(clk), .rst_n(rst_n), .en_i(disp_en), .slot_i(slot), .pol_i(pol),
    .mux_i(mux_cur), .half_i(half_cur), .bits_i(bits),
    .bp_lvl_o(bp_lvl), .seg_lvl_o(seg_lvl)
  );

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_ready); // R11
endmodule

// File: tb/lcd_wave_seq_test.sv
module lcd_wave_seq_test;
  localparam int NS = 160;
  localparam int HZ = 21600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_en = 1'b0;
  logic [1:0] mux_sel = 2'd0;
  logic bias_half = 1'b0;
  logic [2:0] frame_rate = 3'd0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [7:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic [7:0] bp_lvl;
  logic [NS*2-1:0] seg_lvl;

  always #5 clk = ~clk;

  lcd_wave_seq uut (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .mux_sel(mux_sel),
    .bias_half(bias_half), .frame_rate(frame_rate), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .bp_lvl(bp_lvl), .seg_lvl(seg_lvl)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural model state
  int m_cyc = 0, m_pol = 0, m_mux = 0, m_half = 0, m_rate = 0;
  int m_ram [NS];

  function automatic int plen(int code);
    int c = (code > 6) ? 6 : code;
    return HZ / (12 * (60 + 5 * c));
  endfunction

  task automatic check(input string req, input bit ok, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // one clock: model the edge with the inputs held across it, then compare
  task automatic step();
    logic [7:0] e_bp;
    logic [NS*2-1:0] e_seg;
    @(posedge clk); #1;
    e_bp = '0; e_seg = '0;
    if (disp_en) begin
      int n = m_mux + 1;
      int slot = m_cyc / (12 * plen(m_rate) / n);
      for (int b = 0; b < 4; b++) begin
        int idx = (b < n) ? b : 0;
        int pos = (idx == slot) ? 0 : 2;
        e_bp[b*2 +: 2] = 2'(m_pol ? 3 - pos : pos);
      end
      for (int s = 0; s < NS; s++) begin
        int bitv = (m_ram[s] >> slot) & 1;
        int pos = bitv ? 3 : ((m_mux == 0 || m_half != 0) ? 0 : 1);
        e_seg[s*2 +: 2] = 2'(m_pol ? 3 - pos : pos);
      end
    end
    if (!disp_en) begin
      m_cyc = 0; m_pol = 0; m_mux = mux_sel; m_half = bias_half; m_rate = frame_rate;
    end else begin
      m_cyc++;
      if (m_cyc == 12 * plen(m_rate)) begin
        m_cyc = 0; m_pol ^= 1; m_mux = mux_sel; m_half = bias_half; m_rate = frame_rate;
      end
    end
    if (wr_valid && wr_addr < NS) m_ram[wr_addr] = wr_data;
    check(tag, bp_lvl == e_bp && seg_lvl == e_seg,
          $sformatf("bp=%h seg=%h", bp_lvl, seg_lvl),
          $sformatf("bp=%h seg=%h", e_bp, e_seg));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    for (int s = 0; s < NS; s++) m_ram[s] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", bp_lvl == 8'h00 && seg_lvl == '0, $sformatf("%h", bp_lvl), "00");
    check("R1", wr_ready == 1'b1, $sformatf("%b", wr_ready), "1");
    rst_n = 1'b1;
    run(2);

    // fill the display store while blanked (R2 blank, R11 writes)
    tag = "R2";
    for (int s = 0; s < NS; s++) begin
      wr_valid = 1'b1; wr_addr = 8'(s); wr_data = 4'((s * 7 + 3) & 15);
      step();
    end
    wr_addr = 8'd200; wr_data = 4'hF; step();   // ignored address, R11
    wr_valid = 1'b0;
    check("R11", wr_ready == 1'b1, $sformatf("%b", wr_ready), "1");

    // static drive, two frames at 60 Hz
    tag = "R5"; mux_sel = 2'd0; frame_rate = 3'd0; disp_en = 1'b1;
    run(2 * 360 + 5);

    // disable: blanks and rewinds
    tag = "R2"; disp_en = 1'b0; run(4);

    // two-way multiplex, half bias, 70 Hz
    tag = "R6"; mux_sel = 2'd1; bias_half = 1'b1; frame_rate = 3'd2; step();
    disp_en = 1'b1; run(2 * 300 + 3);
    tag = "R12"; run(300);

    // two-way multiplex, third bias
    tag = "R2"; disp_en = 1'b0; bias_half = 1'b0; frame_rate = 3'd5; step();
    tag = "R7"; disp_en = 1'b1; run(2 * 252 + 7);

    // three-way, then mid-frame change to four-way and rate code 7
    tag = "R2"; disp_en = 1'b0; mux_sel = 2'd2; frame_rate = 3'd6; step();
    tag = "R4"; disp_en = 1'b1; run(100);
    tag = "R10"; mux_sel = 2'd3; frame_rate = 3'd7; bias_half = 1'b1; run(3 * 240);
    tag = "R9"; frame_rate = 3'd3; run(2 * 288 + 11);

    // writes while running
    tag = "R8";
    for (int s = 0; s < NS; s += 3) begin
      wr_valid = 1'b1; wr_addr = 8'(s); wr_data = 4'(~s & 15);
      step();
    end
    wr_valid = 1'b0;
    tag = "R3"; bias_half = 1'b0; run(3 * 288);

    // four-way with third bias via a fresh enable
    tag = "R2"; disp_en = 1'b0; frame_rate = 3'd1; step();
    tag = "R11"; disp_en = 1'b1; wr_valid = 1'b1; wr_addr = 8'd5; wr_data = 4'h9; step();
    wr_valid = 1'b0; tag = "R8"; run(2 * 324);

    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
    end
  end
endmodule